// File: doc/BRIEF.md
# Background Tile Fetch Pipeline

This block runs the background half of a tile-based raster generator. It is clocked once per dot and receives the current dot and scanline numbers, the live scroll address, a 3-bit fine horizontal scroll, a pattern table base and two display enables. During each fetch window it repeats an eight-dot cadence. In that cadence it reads a tile index, a palette attribute byte and two bit-plane bytes from video memory through a simple strobe-and-return read port. It packs each tile into eight 4-bit nibbles and shifts them through a 64-bit tile register.

Each visible dot yields one 4-bit background pixel: two palette bits above a 2-bit colour. The fine scroll selects the pixel from the upper half of the tile register. The block does not modify the scroll address. At the end of each tile it raises a one-dot request that tells the surrounding scroll logic to step coarse X, or, on the last visible dot, to step Y.

The 15-bit scroll address is laid out as coarse X in bits 4:0, coarse Y in bits 9:5, the nametable select in bits 11:10 and fine Y in bits 14:12.

Top module: `bg_fetch_pipe`

## Requirements
- R1: `rd_req` is high only on fetch dots (dots 1 to 256 and 321 to 336 of lines 0 to 239 and of line 261) whose low three dot bits are 1, 3, 5 or 7, and it is high on every such dot.
- R2: On a request with dot phase 1, `rd_addr` is 0x2000 OR the low 12 bits of the scroll address.
- R3: On a request with dot phase 3, `rd_addr` is 0x23C0 OR (v AND 0x0C00) OR (v[4:2]) OR (v[9:7] shifted left by 3).
- R4: On phase 5, `rd_addr` is `pat_base` + 16 × (byte returned for the phase-1 read) + v[14:12]. On phase 7 it is that address + 8.
- R5: On fetch dots with dot phase 0, `inc_y` pulses on dot 256 and `inc_x` pulses on every other such dot. Neither pulses anywhere else, and both are never high together.
- R6: Read data is taken on the dot after its request, and a request never lasts two consecutive dots.
- R7: A tile's pixel i (i = 0 leftmost) is the nibble {palette[1:0], high-plane bit 7−i, low-plane bit 7−i}. The palette is (attribute byte >> ((v[1] ? 2 : 0) | (v[6] ? 4 : 0))) AND 3.
- R8: The pixel on dot d shows stream position (d−1) + `fine_x`. The stream starts with the first tile prefetched on the preceding line, and each tile covers eight positions.
- R9: `pixel` is 0 whenever `show_bg` is low. It is also 0 on dots 1 to 8 while `show_left` is low.
- R10: `pixel` is 0 on dot 0, on dots 257 to 340, and on every line that is not 0 to 239.
- R11: While `rst_n` is low, `rd_req`, `inc_x` and `inc_y` are low. After reset the tile register is empty, so the first pixels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dot | input | 9 | Current dot within the line, 0 to 340 |
| line | input | 9 | Current scanline, 0 to 261 |
| scroll_v | input | 15 | Live scroll address |
| fine_x | input | 3 | Fine horizontal scroll |
| pat_base | input | 16 | Background pattern table base address |
| show_bg | input | 1 | Background display enable |
| show_left | input | 1 | Background enable for the leftmost 8 pixels |
| rd_data | input | 8 | Read data, valid on the dot after a request |
| rd_req | output | 1 | Single-dot read strobe |
| rd_addr | output | 16 | Read address, valid with `rd_req` |
| inc_x | output | 1 | Coarse X step request |
| inc_y | output | 1 | Y step request |
| pixel | output | 4 | Background pixel {palette, colour} |

## Verification
Two events share dot phase 0. The high-plane byte arrives and is merged into the low half of the tile register in the same dot that the register shifts. On dot 256 that merge also coincides with the Y step request and the last visible pixel. The bench drives full scanlines and acts as the scroll logic itself, stepping coarse X on every `inc_x`, including across the nametable wrap. It then compares every visible pixel, for all eight fine-scroll values, against a stream computed from the address formulas and a memory pattern defined by arithmetic. A lost shift or a misplaced load on a shared dot therefore shows up as a displaced or merged nibble at the tile seams.

// File: rtl/bg_fetch_pkg.sv
// Shared types and address arithmetic for the background fetch pipeline.
// Assumes the 15-bit scroll layout {fine Y[2:0], nametable[1:0], coarse Y[4:0], coarse X[4:0]}.
package bg_fetch_pkg;

    localparam int SCROLL_W = 15;
    localparam int ADDR_W   = 16;

    // Per-dot operation decoded from the dot phase
    typedef enum logic [3:0] {
        OP_IDLE   = 4'd0,
        OP_REQ_NT = 4'd1,
        OP_CAP_NT = 4'd2,
        OP_REQ_AT = 4'd3,
        OP_CAP_AT = 4'd4,
        OP_REQ_LO = 4'd5,
        OP_CAP_LO = 4'd6,
        OP_REQ_HI = 4'd7,
        OP_LOAD   = 4'd8
    } fetch_op_e;

    // Tile-index address for a scroll value
    function automatic logic [ADDR_W-1:0] tile_index_addr(input logic [SCROLL_W-1:0] v);
        return 16'h2000 | {4'h0, v[11:0]};
    endfunction

    // Attribute byte address for a scroll value
    function automatic logic [ADDR_W-1:0] attr_byte_addr(input logic [SCROLL_W-1:0] v);
        return 16'h23C0 | {4'h0, v[11:10], 10'h000} | {10'h000, v[9:7], v[4:2]};
    endfunction

    // Bit offset of the 2-bit palette inside the attribute byte
    function automatic logic [2:0] attr_shift(input logic [SCROLL_W-1:0] v);
        return {v[6], v[1], 1'b0};
    endfunction

endpackage

// File: rtl/bg_dot_sched.sv
// Dot scheduler: decodes dot and scanline into the fetch window, the
// per-dot fetch operation and the visible-pixel window.
// Assumes dot and line come from an external raster counter.
module bg_dot_sched
    import bg_fetch_pkg::*;
#(
    parameter int DOT_W         = 9,
    parameter int LINE_W        = 9,
    parameter int VIS_DOTS      = 256,
    parameter int PREF_FIRST    = 321,
    parameter int PREF_LAST     = 336,
    parameter int LAST_VIS_LINE = 239,
    parameter int PRE_LINE      = 261,
    parameter int LEFT_COLS     = 8
) (
    input  logic              rst_n,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    output logic              active,
    output fetch_op_e         op,
    output logic              vis_dot,
    output logic              left_col,
    output logic              row_end
);

    localparam logic [DOT_W-1:0]  D_VIS  = DOT_W'(VIS_DOTS);
    localparam logic [DOT_W-1:0]  D_PF0  = DOT_W'(PREF_FIRST);
    localparam logic [DOT_W-1:0]  D_PF1  = DOT_W'(PREF_LAST);
    localparam logic [DOT_W-1:0]  D_LEFT = DOT_W'(LEFT_COLS);
    localparam logic [LINE_W-1:0] L_VIS  = LINE_W'(LAST_VIS_LINE);
    localparam logic [LINE_W-1:0] L_PRE  = LINE_W'(PRE_LINE);

    logic vis_line;
    logic draw_dots;
    logic fetch_dots;

    // Window decode for lines and dots
    always_comb begin
        vis_line   = (line <= L_VIS);
        draw_dots  = (dot >= DOT_W'(1)) && (dot <= D_VIS);
        fetch_dots = draw_dots || ((dot >= D_PF0) && (dot <= D_PF1));
        active     = rst_n && (vis_line || (line == L_PRE)) && fetch_dots;
        vis_dot    = rst_n && vis_line && draw_dots;
        left_col   = (dot <= D_LEFT);
        row_end    = (dot == D_VIS);
    end

    // Phase-to-operation decode, idle outside the window
    always_comb begin
        op = OP_IDLE;
        if (active) begin
            case (dot[2:0])
                3'd1:    op = OP_REQ_NT;
                3'd2:    op = OP_CAP_NT;
                3'd3:    op = OP_REQ_AT;
                3'd4:    op = OP_CAP_AT;
                3'd5:    op = OP_REQ_LO;
                3'd6:    op = OP_CAP_LO;
                3'd7:    op = OP_REQ_HI;
                default: op = OP_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/bg_addr_gen.sv
// Address generator: forms the read strobe and address for the four reads
// of each tile. Assumes the scroll address is stable across a tile group.
module bg_addr_gen
    import bg_fetch_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int VW = SCROLL_W
) (
    input  fetch_op_e      op,
    input  logic [VW-1:0]  scroll_v,
    input  logic [AW-1:0]  pat_base,
    input  logic [7:0]     tile_idx,
    output logic           rd_req,
    output logic [AW-1:0]  rd_addr
);

    logic [AW-1:0] plane_addr;

    // Pattern row address of the low plane
    always_comb begin
        plane_addr = pat_base + AW'({tile_idx, 4'h0}) + AW'(scroll_v[14:12]);
    end

    // Strobe and address mux per operation
    always_comb begin
        rd_req  = 1'b1;
        rd_addr = '0;
        case (op)
            OP_REQ_NT: rd_addr = AW'(tile_index_addr(scroll_v));
            OP_REQ_AT: rd_addr = AW'(attr_byte_addr(scroll_v));
            OP_REQ_LO: rd_addr = plane_addr;
            OP_REQ_HI: rd_addr = plane_addr + AW'(8);
            default:   rd_req  = 1'b0;
        endcase
    end

endmodule

// File: rtl/bg_tile_shift.sv
// Tile shifter: captures returned bytes, builds eight pixel nibbles per tile,
// shifts the 64-bit tile register and selects the fine-scrolled nibble.
// Assumes read data is valid on the dot after its request.
module bg_tile_shift
    import bg_fetch_pkg::*;
#(
    parameter int VW       = SCROLL_W,
    parameter int TILE_PIX = 8,
    parameter int NIB_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          active,
    input  fetch_op_e                     op,
    input  logic [7:0]                    rd_data,
    input  logic [VW-1:0]                 scroll_v,
    input  logic [$clog2(TILE_PIX)-1:0]   fine_x,
    output logic [7:0]                    tile_idx,
    output logic [NIB_W-1:0]              pix_raw
);

    localparam int HALF_W = TILE_PIX * NIB_W;
    localparam int TILE_W = 2 * HALF_W;

    logic [1:0]        pal_q;
    logic [7:0]        lo_q;
    logic [7:0]        hi_now;
    logic [HALF_W-1:0] load_word;
    logic [TILE_W-1:0] tile_q;
    logic [7:0]        attr_sh;

    assign hi_now  = rd_data;
    assign attr_sh = rd_data >> attr_shift(scroll_v);

    // Capture tile index, palette and low plane on their return dots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tile_idx <= '0;
            pal_q    <= '0;
            lo_q     <= '0;
        end else begin
            if (op == OP_CAP_NT) tile_idx <= rd_data;
            if (op == OP_CAP_AT) pal_q    <= attr_sh[1:0];
            if (op == OP_CAP_LO) lo_q     <= rd_data;
        end
    end

    // One nibble per pixel slot: slot j holds plane bit j, leftmost in the top slot
    for (genvar j = 0; j < TILE_PIX; j++) begin : g_slot
        assign load_word[j*NIB_W +: NIB_W] = {pal_q, hi_now[j], lo_q[j]};
    end

    // Shift every fetch dot, merge a new tile into the low half on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tile_q <= '0;
        end else if (active) begin
            if (op == OP_LOAD)
                tile_q <= (tile_q << NIB_W) | {{HALF_W{1'b0}}, load_word};
            else
                tile_q <= tile_q << NIB_W;
        end
    end

    // Fine scroll selects a nibble of the upper half
    always_comb begin
        pix_raw = tile_q[(TILE_W - 1 - int'(fine_x) * NIB_W) -: NIB_W];
    end

endmodule

// File: rtl/bg_fetch_pipe.sv
// Background tile fetch pipeline top: schedules the eight-dot fetch cadence,
// issues reads, signals scroll steps and outputs one blanked pixel per dot.
// Assumes an external raster counter and external scroll-step logic.
module bg_fetch_pipe
    import bg_fetch_pkg::*;
#(
    parameter int DOT_W         = 9,
    parameter int LINE_W        = 9,
    parameter int AW            = ADDR_W,
    parameter int VW            = SCROLL_W,
    parameter int TILE_PIX      = 8,
    parameter int NIB_W         = 4,
    parameter int VIS_DOTS      = 256,
    parameter int PREF_FIRST    = 321,
    parameter int PREF_LAST     = 336,
    parameter int LAST_VIS_LINE = 239,
    parameter int PRE_LINE      = 261
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DOT_W-1:0]            dot,
    input  logic [LINE_W-1:0]           line,
    input  logic [VW-1:0]               scroll_v,
    input  logic [$clog2(TILE_PIX)-1:0] fine_x,
    input  logic [AW-1:0]               pat_base,
    input  logic                        show_bg,
    input  logic                        show_left,
    input  logic [7:0]                  rd_data,
    output logic                        rd_req,
    output logic [AW-1:0]               rd_addr,
    output logic                        inc_x,
    output logic                        inc_y,
    output logic [NIB_W-1:0]            pixel
);

    fetch_op_e        op;
    logic             active;
    logic             vis_dot;
    logic             left_col;
    logic             row_end;
    logic [7:0]       tile_idx;
    logic [NIB_W-1:0] pix_raw;

    bg_dot_sched #(
        .DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_DOTS(VIS_DOTS),
        .PREF_FIRST(PREF_FIRST), .PREF_LAST(PREF_LAST),
        .LAST_VIS_LINE(LAST_VIS_LINE), .PRE_LINE(PRE_LINE), .LEFT_COLS(TILE_PIX)
    ) u_sched (
        .rst_n(rst_n), .dot(dot), .line(line), .active(active), .op(op),
        .vis_dot(vis_dot), .left_col(left_col), .row_end(row_end)
    );

    bg_addr_gen #(.AW(AW), .VW(VW)) u_addr (
        .op(op), .scroll_v(scroll_v), .pat_base(pat_base), .tile_idx(tile_idx),
        .rd_req(rd_req), .rd_addr(rd_addr)
    );

    bg_tile_shift #(.VW(VW), .TILE_PIX(TILE_PIX), .NIB_W(NIB_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .active(active), .op(op), .rd_data(rd_data),
        .scroll_v(scroll_v), .fine_x(fine_x), .tile_idx(tile_idx), .pix_raw(pix_raw)
    );

    // Scroll step requests at the end of each tile
    always_comb begin
        inc_y = (op == OP_LOAD) && row_end;
        inc_x = (op == OP_LOAD) && !row_end;
    end

    // Display enables and visible window gate the pixel
    always_comb begin
        if (vis_dot && show_bg && !(left_col && !show_left))
            pixel = pix_raw;
        else
            pixel = '0;
    end

endmodule

// File: rtl/bg_fetch_chk.sv
// Protocol checker for the background fetch pipeline, bound to the top.
module bg_fetch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [8:0]  dot,
    input logic [8:0]  line,
    input logic        show_bg,
    input logic        rd_req,
    input logic [15:0] rd_addr,
    input logic        inc_x,
    input logic        inc_y,
    input logic [3:0]  pixel
);

    AST_REQ_ODD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> dot[0]); // R1

    AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ((line <= 9'd239 || line == 9'd261) &&
                    ((dot >= 9'd1 && dot <= 9'd256) || (dot >= 9'd321 && dot <= 9'd336)))); // R1

    AST_HI_PLANE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && dot[2:0] == 3'd7 && $past(rd_req, 2) && $past(dot, 2) == dot - 9'd2)
        |-> rd_addr == $past(rd_addr, 2) + 16'd8); // R4

    AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_x && inc_y)); // R5

    AST_STEP_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_x || inc_y) |-> (dot[2:0] == 3'd0 && !rd_req)); // R5

    AST_REQ_SINGLE_DOT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R6

    AST_BLANK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !show_bg |-> pixel == 4'd0); // R9

    AST_BLANK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (dot == 9'd0 || dot > 9'd256 || line > 9'd239) |-> pixel == 4'd0); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!rd_req && !inc_x && !inc_y)); // R11

endmodule

bind bg_fetch_pipe bg_fetch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .show_bg(show_bg),
    .rd_req(rd_req), .rd_addr(rd_addr), .inc_x(inc_x), .inc_y(inc_y), .pixel(pixel)
);

// File: tb/sim_bg_fetch_pipe.sv
module sim_bg_fetch_pipe;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  dot = '0;
    logic [8:0]  line = '0;
    logic [14:0] scroll_v = '0;
    logic [2:0]  fine_x = '0;
    logic [15:0] pat_base = '0;
    logic        show_bg = 1'b0;
    logic        show_left = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        inc_x;
    logic        inc_y;
    logic [3:0]  pixel;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bg_fetch_pipe u0 (
        .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .scroll_v(scroll_v),
        .fine_x(fine_x), .pat_base(pat_base), .show_bg(show_bg), .show_left(show_left),
        .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr), .inc_x(inc_x),
        .inc_y(inc_y), .pixel(pixel)
    );

    // Memory pattern defined by arithmetic
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return 8'(a[7:0] ^ (a[15:8] * 8'd7) ^ 8'h5A ^ {a[2:0], 5'd0});
    endfunction

    // Memory model: data returns on the dot after a request (R6)
    always @(posedge clk) if (rd_req) rd_data <= mem_byte(rd_addr);

    function automatic logic [15:0] nt_of(input logic [14:0] v);
        return {4'h2, v[11:0]};
    endfunction

    function automatic logic [15:0] at_of(input logic [14:0] v);
        return 16'h23C0 | {4'h0, v[11:10], 10'd0} | {10'd0, v[9:7], 3'd0} | {13'd0, v[4:2]};
    endfunction

    function automatic logic [15:0] lo_of(input logic [14:0] v, input logic [15:0] base);
        return base + {4'd0, mem_byte(nt_of(v)), 4'd0} + {13'd0, v[14:12]};
    endfunction

    // Coarse X step with nametable wrap, as external scroll logic would do
    function automatic logic [14:0] step_x(input logic [14:0] v);
        logic [14:0] r;
        r = v;
        if (v[4:0] == 5'd31) begin
            r[4:0] = 5'd0;
            r[10]  = ~v[10];
        end else begin
            r[4:0] = v[4:0] + 5'd1;
        end
        return r;
    endfunction

    // Expected pixel for screen x given the line's starting scroll (R7, R8)
    function automatic logic [3:0] exp_pix(input logic [14:0] vl, input int x);
        logic [14:0] vt;
        logic [7:0]  atb, lo, hi;
        logic [1:0]  pal;
        int p, t, b, sh;
        p  = x + int'(fine_x);
        t  = p / 8;
        b  = 7 - (p % 8);
        vt = vl;
        for (int k = 0; k < t; k++) vt = step_x(vt);
        atb = mem_byte(at_of(vt));
        sh  = (vt[1] ? 2 : 0) + (vt[6] ? 4 : 0);
        pal = 2'((atb >> sh) & 8'd3);
        lo  = mem_byte(lo_of(vt, pat_base));
        hi  = mem_byte(lo_of(vt, pat_base) + 16'd8);
        return {pal, hi[b], lo[b]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s line=%0d dot=%0d actual=%0h expected=%0h", req, line, dot, act, exp);
        end
    endtask

    // Run one scanline; vl is the line's starting scroll, vnext is copied in at dot 257
    task automatic run_line(input int ln, input logic [14:0] vl, input logic [14:0] vnext);
        logic [14:0] vcur;
        logic        fetch_dot, was_inc;
        int          ph;
        vcur = scroll_v;
        for (int d = 0; d <= 340; d++) begin
            if (d == 257) vcur = vnext;
            dot = 9'(d);
            line = 9'(ln);
            scroll_v = vcur;
            @(negedge clk);
            ph = d % 8;
            fetch_dot = (ln <= 239 || ln == 261) && ((d >= 1 && d <= 256) || (d >= 321 && d <= 336));
            check("R1", {31'd0, rd_req}, {31'd0, fetch_dot && (ph % 2 == 1)});
            if (fetch_dot && ph == 1) check("R2", {16'd0, rd_addr}, {16'd0, nt_of(vcur)});
            if (fetch_dot && ph == 3) check("R3", {16'd0, rd_addr}, {16'd0, at_of(vcur)});
            if (fetch_dot && ph == 5) check("R4", {16'd0, rd_addr}, {16'd0, lo_of(vcur, pat_base)});
            if (fetch_dot && ph == 7) check("R4", {16'd0, rd_addr}, {16'd0, lo_of(vcur, pat_base) + 16'd8});
            check("R5", {30'd0, inc_y, inc_x},
                  {30'd0, fetch_dot && ph == 0 && d == 256, fetch_dot && ph == 0 && d != 256});
            if (ln <= 239 && d >= 1 && d <= 256) begin
                if (!show_bg || (d <= 8 && !show_left))
                    check("R9", {28'd0, pixel}, 32'd0);
                else
                    check("R8", {28'd0, pixel}, {28'd0, exp_pix(vl, d - 1)});
            end else begin
                check("R10", {28'd0, pixel}, 32'd0);
            end
            was_inc = inc_x;
            @(posedge clk);
            #1;
            if (was_inc) vcur = step_x(vcur);
        end
    endtask

    // One configuration: pre-render line, two visible lines, one idle line
    task automatic run_cfg(input logic [14:0] v0, input logic [2:0] fx, input logic [15:0] base,
                           input logic sb, input logic sl);
        logic [14:0] v1;
        v1 = v0 + 15'h1000;
        fine_x = fx;
        pat_base = base;
        show_bg = sb;
        show_left = sl;
        run_line(261, v0, v0);
        run_line(0, v0, v1);
        run_line(1, v1, v1);
        run_line(240, v1, v1);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // Reset held during a fetch dot: no strobes (R11)
        line = 9'd0;
        dot = 9'd1;
        show_bg = 1'b1;
        show_left = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", {29'd0, rd_req, inc_x, inc_y}, 32'd0);
        dot = 9'd8;
        @(negedge clk);
        check("R11", {29'd0, rd_req, inc_x, inc_y}, 32'd0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        dot = 9'd0;
        line = 9'd240;
        @(posedge clk);
        #1;
        // Empty tile register after reset gives a zero pixel (R11)
        line = 9'd0;
        dot = 9'd2;
        @(negedge clk);
        check("R11", {28'd0, pixel}, 32'd0);
        @(posedge clk);
        #1;
        // Fine scroll sweep with varied scroll and pattern base (R7, R8)
        for (int f = 0; f < 8; f++)
            run_cfg(15'(f * 4111 + 37), 3'(f), (f % 2 == 1) ? 16'h1000 : 16'h0000, 1'b1, 1'b1);
        // Coarse X start at 31: nametable wrap during prefetch (R8)
        run_cfg(15'h245F, 3'd5, 16'h0000, 1'b1, 1'b1);
        // Left column blanked (R9)
        run_cfg(15'h3123, 3'd3, 16'h1000, 1'b1, 1'b0);
        // Background disabled (R9)
        run_cfg(15'h0A4C, 3'd7, 16'h0000, 1'b0, 1'b1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule